// File: doc/BRIEF.md
# Segmented Word Stack Engine

This block keeps a last-in-first-out stack of 16-bit words inside a memory that is only one byte wide. A segment register and a 16-bit offset pointer together locate the top of the stack. Every push splits the word into two single-byte writes, and every pop joins two single-byte reads back into a word. The block drives a synchronous byte memory port with one access per cycle. It reports `busy` for as long as a word transfer is running, and it returns each popped word together with a one-cycle valid strobe.

The block drops any request that arrives while it is busy. The pointer and the segment can be reloaded in one cycle. A pop that names the code-segment register as its destination is refused and flagged, and it never touches the memory.

Top module: `wordStackEngine`

## Requirements
- R1: A push writes the high byte at offset pointer-1 in the first cycle after acceptance. It writes the low byte at offset pointer-2 in the next cycle. `memWe` is high in both cycles.
- R2: When a push completes, `curPtr` has decreased by 2, modulo 2^16.
- R3: A pop reads offset pointer (the low byte) in the first cycle after acceptance and offset pointer+1 (the high byte) in the next cycle. The memory returns read data one cycle after `memRe`. `popValid` pulses for one cycle, three cycles after acceptance, with `popData` = {high, low}. At the same moment `curPtr` has increased by 2, modulo 2^16.
- R4: The physical address `memAddr` is segment*16 plus the 16-bit offset, truncated to 20 bits. Offsets wrap inside the segment.
- R5: A pop with `popToCode`=1 is refused. `illegalPop` pulses for one cycle after acceptance. There is no memory access, `curPtr` does not change and `busy` stays low.
- R6: `loadReq` sets `curSeg` and `curPtr` in one clock edge. It makes no memory access and does not raise `busy`.
- R7: `busy` stays high for exactly 2 cycles after a push is accepted and for exactly 3 cycles after a pop is accepted. Any request that arrives while `busy` is high is ignored.
- R8: When requests arrive together in an idle cycle, load wins over push and push wins over pop.
- R9: After reset, `curSeg`=0, `curPtr`=0, and `busy`, `memWe`, `memRe`, `popValid` and `illegalPop` are all 0.
- R10: Words pop back out in the reverse of the order in which they were pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadReq | input | 1 | Load segment and pointer |
| loadSeg | input | 16 | Segment value to load |
| loadPtr | input | 16 | Pointer value to load |
| pushReq | input | 1 | Push request |
| pushData | input | 16 | Word to push |
| popReq | input | 1 | Pop request |
| popToCode | input | 1 | Pop destination is the code-segment register |
| memAddr | output | 20 | Physical byte address |
| memWe | output | 1 | Byte write strobe |
| memRe | output | 1 | Byte read strobe |
| memWdata | output | 8 | Byte to write |
| memRdata | input | 8 | Read byte, one cycle after memRe |
| popData | output | 16 | Popped word |
| popValid | output | 1 | popData valid, one-cycle pulse |
| illegalPop | output | 1 | Refused pop, one-cycle pulse |
| busy | output | 1 | Transfer in progress |
| curSeg | output | 16 | Current stack segment |
| curPtr | output | 16 | Current stack pointer |

## Verification
An error in the sequencer shows up at the ports within one cycle, because `busy` keeps the wrong length or `memAddr` shows the wrong byte order. An error in the pointer appears on `curPtr` as soon as the transfer ends. It also misplaces every later access, so the next pop returns a mismatched word. A slip in the low-byte holding register corrupts only the low half of `popData`, and it is visible on the cycle `popValid` is high. The sweep pairs each push with its pop across several segment and pointer values, including both wrap edges, so that an address fault appears as a wrong address in the logged access sequence.

// File: rtl/wordStackPkg.sv
package wordStackPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_HI,
    ST_PUSH_LO,
    ST_POP_LO,
    ST_POP_HI,
    ST_POP_DONE
  } stackState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadRegs;
    logic takePush;
    logic writeHi;
    logic writeLo;
    logic readLo;
    logic readHi;
    logic finishPop;
    logic flagIllegal;
  } stackStrobes_t;

endpackage

// File: rtl/wordStackCtrl.sv
module wordStackCtrl
  import wordStackPkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          loadReq,
  input  logic          pushReq,
  input  logic          popReq,
  input  logic          popToCode,
  output logic          busy,
  output stackStrobes_t strb
);

  stackState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    case (state)
      ST_IDLE: begin
        // priority: load, then push, then pop (R8)
        if (loadReq) begin
          strb.loadRegs = 1'b1;
        end else if (pushReq) begin
          strb.takePush = 1'b1;
          nextState     = ST_PUSH_HI;
        end else if (popReq) begin
          if (popToCode) strb.flagIllegal = 1'b1;
          else           nextState        = ST_POP_LO;
        end
      end
      ST_PUSH_HI: begin
        strb.writeHi = 1'b1;
        nextState    = ST_PUSH_LO;
      end
      ST_PUSH_LO: begin
        strb.writeLo = 1'b1;
        nextState    = ST_IDLE;
      end
      ST_POP_LO: begin
        strb.readLo = 1'b1;
        nextState   = ST_POP_HI;
      end
      ST_POP_HI: begin
        strb.readHi = 1'b1;
        nextState   = ST_POP_DONE;
      end
      ST_POP_DONE: begin
        strb.finishPop = 1'b1;
        nextState      = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/wordStackDatapath.sv
module wordStackDatapath
  import wordStackPkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int OFF_W     = 16,
  parameter int SEG_W     = 16,
  parameter int PHYS_W    = 20,
  parameter int SEG_SHIFT = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  stackStrobes_t       strb,
  input  logic [SEG_W-1:0]    loadSeg,
  input  logic [OFF_W-1:0]    loadPtr,
  input  logic [2*BYTE_W-1:0] pushData,
  input  logic [BYTE_W-1:0]   memRdata,
  output logic [PHYS_W-1:0]   memAddr,
  output logic                memWe,
  output logic                memRe,
  output logic [BYTE_W-1:0]   memWdata,
  output logic [2*BYTE_W-1:0] popData,
  output logic                popValid,
  output logic                illegalPop,
  output logic [SEG_W-1:0]    curSeg,
  output logic [OFF_W-1:0]    curPtr
);

  localparam int WORD_W = 2 * BYTE_W;
  localparam logic [OFF_W-1:0] STEP1 = OFF_W'(1);
  localparam logic [OFF_W-1:0] STEP2 = OFF_W'(2);

  logic [SEG_W-1:0]  segReg;
  logic [OFF_W-1:0]  ptrReg;
  logic [WORD_W-1:0] pushWord;
  logic [BYTE_W-1:0] loByte;
  logic [OFF_W-1:0]  offset;
  logic [PHYS_W-1:0] segBase;

  // offset within the segment, wrapping modulo 2^OFF_W
  always_comb begin
    if (strb.writeHi)      offset = ptrReg - STEP1;
    else if (strb.writeLo) offset = ptrReg - STEP2;
    else if (strb.readHi)  offset = ptrReg + STEP1;
    else                   offset = ptrReg;
  end

  assign segBase  = PHYS_W'(segReg) << SEG_SHIFT;
  assign memAddr  = segBase + PHYS_W'(offset);
  assign memWe    = strb.writeHi | strb.writeLo;
  assign memRe    = strb.readLo | strb.readHi;
  assign memWdata = strb.writeHi ? pushWord[WORD_W-1:BYTE_W] : pushWord[BYTE_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      segReg     <= '0;
      ptrReg     <= '0;
      pushWord   <= '0;
      loByte     <= '0;
      popData    <= '0;
      popValid   <= 1'b0;
      illegalPop <= 1'b0;
    end else begin
      popValid   <= strb.finishPop;
      illegalPop <= strb.flagIllegal;
      if (strb.loadRegs) begin
        segReg <= loadSeg;
        ptrReg <= loadPtr;
      end
      if (strb.takePush) pushWord <= pushData;
      if (strb.writeLo)  ptrReg   <= ptrReg - STEP2;
      // low byte returns during the high-byte read cycle
      if (strb.readHi)   loByte   <= memRdata;
      if (strb.finishPop) begin
        popData <= {memRdata, loByte};
        ptrReg  <= ptrReg + STEP2;
      end
    end
  end

  assign curSeg = segReg;
  assign curPtr = ptrReg;

endmodule

// File: rtl/wordStackEngine.sv
module wordStackEngine
  import wordStackPkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int OFF_W     = 16,
  parameter int SEG_W     = 16,
  parameter int PHYS_W    = 20,
  parameter int SEG_SHIFT = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                loadReq,
  input  logic [SEG_W-1:0]    loadSeg,
  input  logic [OFF_W-1:0]    loadPtr,
  input  logic                pushReq,
  input  logic [2*BYTE_W-1:0] pushData,
  input  logic                popReq,
  input  logic                popToCode,
  output logic [PHYS_W-1:0]   memAddr,
  output logic                memWe,
  output logic                memRe,
  output logic [BYTE_W-1:0]   memWdata,
  input  logic [BYTE_W-1:0]   memRdata,
  output logic [2*BYTE_W-1:0] popData,
  output logic                popValid,
  output logic                illegalPop,
  output logic                busy,
  output logic [SEG_W-1:0]    curSeg,
  output logic [OFF_W-1:0]    curPtr
);

  stackStrobes_t strb;

  wordStackCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .loadReq   (loadReq),
    .pushReq   (pushReq),
    .popReq    (popReq),
    .popToCode (popToCode),
    .busy      (busy),
    .strb      (strb)
  );

  wordStackDatapath #(
    .BYTE_W    (BYTE_W),
    .OFF_W     (OFF_W),
    .SEG_W     (SEG_W),
    .PHYS_W    (PHYS_W),
    .SEG_SHIFT (SEG_SHIFT)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .loadSeg    (loadSeg),
    .loadPtr    (loadPtr),
    .pushData   (pushData),
    .memRdata   (memRdata),
    .memAddr    (memAddr),
    .memWe      (memWe),
    .memRe      (memRe),
    .memWdata   (memWdata),
    .popData    (popData),
    .popValid   (popValid),
    .illegalPop (illegalPop),
    .curSeg     (curSeg),
    .curPtr     (curPtr)
  );

endmodule

// File: rtl/wordStackChecker.sv
module wordStackChecker #(
  parameter int OFF_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             memWe,
  input logic             memRe,
  input logic             busy,
  input logic             popValid,
  input logic             illegalPop,
  input logic [OFF_W-1:0] curPtr
);

  // R1: the block never reads and writes in the same cycle
  a_r1_one_access: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({memWe, memRe}));

  // R2: the pointer drops by two after the second byte of a push
  a_r2_push_step: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && $past(memWe)) |=> (curPtr == $past(curPtr) - OFF_W'(2)));

  // R3: popValid is a single-cycle pulse
  a_r3_valid_pulse: assert property (@(posedge clk) disable iff (!rstN)
    popValid |=> !popValid);

  // R3: the word comes back after two reads and one further cycle
  a_r3_valid_after_reads: assert property (@(posedge clk) disable iff (!rstN)
    popValid |-> ($past(memRe, 2) && $past(memRe, 3) && !$past(memRe)));

  // R5: a refused pop makes no access and leaves the pointer alone
  a_r5_illegal_quiet: assert property (@(posedge clk) disable iff (!rstN)
    illegalPop |-> (!memWe && !memRe && !busy && $stable(curPtr)));

  // R7: memory is touched only while busy
  a_r7_access_in_busy: assert property (@(posedge clk) disable iff (!rstN)
    (memWe || memRe) |-> busy);

endmodule

bind wordStackEngine wordStackChecker #(.OFF_W(OFF_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .memWe      (memWe),
  .memRe      (memRe),
  .busy       (busy),
  .popValid   (popValid),
  .illegalPop (illegalPop),
  .curPtr     (curPtr)
);

// File: tb/tb_wordStackEngine.sv
`timescale 1ns/1ps
module tb_wordStackEngine;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadReq = 1'b0, pushReq = 1'b0, popReq = 1'b0, popToCode = 1'b0;
  logic [15:0] loadSeg = '0, loadPtr = '0, pushData = '0;
  logic [19:0] memAddr;
  logic        memWe, memRe;
  logic [7:0]  memWdata;
  logic [7:0]  memRdata = '0;
  logic [15:0] popData;
  logic        popValid, illegalPop, busy;
  logic [15:0] curSeg, curPtr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0]  ram [int unsigned];
  logic [19:0] wAddr [0:3];
  logic [7:0]  wData [0:3];
  logic [19:0] rAddr [0:3];
  int wCount = 0;
  int rCount = 0;

  logic [15:0] mSeg = '0, mPtr = '0;

  always #10 clk = ~clk;

  wordStackEngine dut (
    .clk(clk), .rstN(rstN), .loadReq(loadReq), .loadSeg(loadSeg), .loadPtr(loadPtr),
    .pushReq(pushReq), .pushData(pushData), .popReq(popReq), .popToCode(popToCode),
    .memAddr(memAddr), .memWe(memWe), .memRe(memRe), .memWdata(memWdata),
    .memRdata(memRdata), .popData(popData), .popValid(popValid),
    .illegalPop(illegalPop), .busy(busy), .curSeg(curSeg), .curPtr(curPtr)
  );

  // byte memory with one cycle read latency
  always @(posedge clk) begin
    if (memWe) begin
      if (wCount < 4) begin
        wAddr[wCount] = memAddr;
        wData[wCount] = memWdata;
      end
      wCount = wCount + 1;
      ram[int'(memAddr)] = memWdata;
    end
    if (memRe) begin
      if (rCount < 4) rAddr[rCount] = memAddr;
      rCount = rCount + 1;
      memRdata <= ram.exists(int'(memAddr)) ? ram[int'(memAddr)] : 8'h00;
    end
  end

  function automatic logic [19:0] phys(logic [15:0] s, logic [15:0] o);
    return ({4'h0, s} << 4) + {4'h0, o};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic doLoad(logic [15:0] s, logic [15:0] p);
    @(negedge clk);
    loadReq = 1'b1; loadSeg = s; loadPtr = p;
    wCount = 0; rCount = 0;
    @(negedge clk);
    loadReq = 1'b0;
    mSeg = s; mPtr = p;
    check("R6 seg", curSeg, s);
    check("R6 ptr", curPtr, p);
    check("R6 busy", busy, 0);
    check("R6 no access", wCount + rCount, 0);
  endtask

  task automatic doPush(logic [15:0] w, bit poke);
    int n;
    @(negedge clk);
    pushReq = 1'b1; pushData = w;
    wCount = 0; rCount = 0;
    @(negedge clk);
    pushReq = 1'b0;
    n = 0;
    while (busy && n < 10) begin
      n++;
      if (poke && n == 1) begin
        pushReq = 1'b1; popReq = 1'b1; loadReq = 1'b1;
        loadSeg = ~mSeg; loadPtr = ~mPtr; pushData = ~w;
      end
      @(negedge clk);
      pushReq = 1'b0; popReq = 1'b0; loadReq = 1'b0;
    end
    check("R7 push busy cycles", n, 2);
    check("R1 write count", wCount, 2);
    check("R1 hi addr", wAddr[0], phys(mSeg, mPtr - 16'd1));
    check("R1 hi data", wData[0], w[15:8]);
    check("R1 lo addr", wAddr[1], phys(mSeg, mPtr - 16'd2));
    check("R1 lo data", wData[1], w[7:0]);
    mPtr = mPtr - 16'd2;
    check("R2 ptr after push", curPtr, mPtr);
    if (poke) begin
      check("R7 seg untouched while busy", curSeg, mSeg);
      check("R7 no reads while busy", rCount, 0);
    end
  endtask

  task automatic doPop(logic [15:0] w);
    int n;
    @(negedge clk);
    popReq = 1'b1;
    wCount = 0; rCount = 0;
    @(negedge clk);
    popReq = 1'b0;
    n = 0;
    while (busy && n < 10) begin
      n++;
      @(negedge clk);
    end
    check("R7 pop busy cycles", n, 3);
    check("R3 read count", rCount, 2);
    check("R3 lo addr", rAddr[0], phys(mSeg, mPtr));
    check("R3 hi addr", rAddr[1], phys(mSeg, mPtr + 16'd1));
    check("R3 valid", popValid, 1);
    check("R3 data", popData, w);
    mPtr = mPtr + 16'd2;
    check("R3 ptr after pop", curPtr, mPtr);
    @(negedge clk);
    check("R3 valid pulse ends", popValid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 busy", busy, 0);
    check("R9 seg", curSeg, 0);
    check("R9 ptr", curPtr, 0);
    check("R9 strobes", {memWe, memRe, popValid, illegalPop}, 0);
    rstN = 1'b1;

    // R4 sweep over segment and pointer edges, including wrap
    for (int i = 0; i < 4; i++) begin
      for (int j = 0; j < 7; j++) begin
        logic [15:0] s, p, w;
        case (i)
          0: s = 16'h0000; 1: s = 16'h1234; 2: s = 16'hFFFF; default: s = 16'h8000;
        endcase
        case (j)
          0: p = 16'h0000; 1: p = 16'h0001; 2: p = 16'h0002; 3: p = 16'hFFFF;
          4: p = 16'hFFFE; 5: p = 16'h8001; default: p = 16'h0100;
        endcase
        w = 16'hA5C3 ^ (16'(i) * 16'h1111 + 16'(j) * 16'h0203);
        doLoad(s, p);
        doPush(w, 1'b0);
        doPop(w);
        check("R4 ptr restored", curPtr, p);
      end
    end

    // R10 LIFO order
    doLoad(16'h2000, 16'h0400);
    for (int k = 0; k < 4; k++) doPush(16'h1000 * 16'(k + 1) + 16'h00AB, 1'b0);
    for (int k = 3; k >= 0; k--) doPop(16'h1000 * 16'(k + 1) + 16'h00AB);
    check("R10 ptr home", curPtr, 16'h0400);

    // R7 requests while busy are ignored
    doPush(16'hBEEF, 1'b1);
    doPop(16'hBEEF);

    // R5 refused pop
    doPush(16'h7E81, 1'b0);
    @(negedge clk);
    popReq = 1'b1; popToCode = 1'b1; wCount = 0; rCount = 0;
    @(negedge clk);
    popReq = 1'b0; popToCode = 1'b0;
    check("R5 illegal flag", illegalPop, 1);
    check("R5 not busy", busy, 0);
    check("R5 ptr unchanged", curPtr, mPtr);
    @(negedge clk);
    check("R5 flag pulse", illegalPop, 0);
    check("R5 no access", wCount + rCount, 0);
    doPop(16'h7E81);

    // R8 load beats push
    @(negedge clk);
    loadReq = 1'b1; pushReq = 1'b1; loadSeg = 16'h0ABC; loadPtr = 16'h0050;
    wCount = 0; rCount = 0;
    @(negedge clk);
    loadReq = 1'b0; pushReq = 1'b0;
    mSeg = 16'h0ABC; mPtr = 16'h0050;
    check("R8 load wins ptr", curPtr, 16'h0050);
    check("R8 load wins busy", busy, 0);
    @(negedge clk);
    check("R8 load wins no write", wCount, 0);

    // R8 push beats pop
    @(negedge clk);
    pushReq = 1'b1; popReq = 1'b1; pushData = 16'h3C5A;
    wCount = 0; rCount = 0;
    @(negedge clk);
    pushReq = 1'b0; popReq = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 push wins writes", wCount, 2);
    check("R8 push wins no reads", rCount, 0);
    mPtr = mPtr - 16'd2;
    check("R8 push wins ptr", curPtr, mPtr);
    doPop(16'h3C5A);

    finishRun();
  end

endmodule